// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial memory interface that serves reads only. It watches oversampled clock and data lines, recognises start, stop and repeated-start conditions, checks the device address byte, and accepts a two-byte word address. The word address goes into one shared address counter, so a master can position the counter and read from it, either in the same transfer or in a later one.

Every read, whether current-address or random, returns bytes from the address counter. The master's acknowledge in the ninth clock of each byte decides whether the next byte follows. The counter advances after every byte sent and wraps around the whole array. The array is a small register file that reset fills with a computed pattern. Programming the array is not part of this block. A write header exists only to carry the word address.

The data line is open-drain. The block never drives it high and only asserts a pull-low enable.

Top module: `i2c_mem_read_slave`

## Requirements
- R1: After reset the pull-low enable is off and the address counter is 0. Array location i holds (i*29 + 167) mod 256, for i from 0 to 2**ADDR_W-1.
- R2: A falling data edge while the clock is high is a start, and a rising data edge while the clock is high is a stop. A start is recognised in every state, including in the middle of a word address byte, and begins a new header.
- R3: The first byte after a start carries a 7-bit device address, MSB first, followed by a direction bit (1 = read). On a match with DEV_ADDR the slave pulls the line low in the ninth clock. On a mismatch it does not acknowledge, and it ignores all later bytes until the next start.
- R4: After a header with the direction bit 0, two word address bytes follow, high byte first, and each is acknowledged. The low ADDR_W bits of the 16-bit value are loaded into the address counter, and higher bits are ignored.
- R5: A stop after the two word address bytes leaves the loaded value in the counter and returns no data.
- R6: A repeated start after the word address bytes, followed by a read header, returns the byte at the loaded address.
- R7: A read header sent right after a start returns the byte at the current counter value.
- R8: Each data byte is 8 bits, sent MSB first. A 1 bit is sent by leaving the line released.
- R9: When the master pulls the line low in the ninth clock, the next byte follows from the counter plus one. After address 2**ADDR_W-1 the counter wraps to 0. The counter advances once per byte sent.
- R10: If the line stays high in the ninth clock, the slave stops driving and ignores further clocks until a start or stop.
- R11: A stop issued in the ninth clock of a read byte ends the read, and the counter has already advanced past that byte.
- R12: After any stop, clocked bytes without a new start are ignored and the line is never pulled low.
- R13: The pull-low enable changes only while the clock is low, and the line seen by the master is stable throughout every clock-high phase of a data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
The bench builds the block with its defaults: device address 0x50, ADDR_W = 5 (32 locations) and a two-stage synchroniser. Thirty-two locations make the wrap from the top address back to 0 reachable within one short sequential read. Random 16-bit word addresses almost always have bits set above ADDR_W, so every random read also tests the truncation. The bus bit time of sixteen system clocks leaves room for the synchroniser latency before each sample point.

// File: rtl/srd_pkg.sv
// Package for the serial memory read slave: controller states, header byte
// selectors and the reset fill pattern of the array.
package srd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // standby, waits for a start
        ST_RX,       // shifting in a header or word address byte
        ST_ACKPEND,  // byte taken, ack goes out at next clock low
        ST_ACK,      // slave holds the ack bit
        ST_TX,       // shifting out a data byte
        ST_MACK,     // ninth clock of a read, master answers
        ST_NEXT      // master acknowledged, next byte at next clock low
    } srd_state_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_AHI,
        BY_ALO
    } srd_byte_e;

    // Reset content of array location idx.
    function automatic logic [7:0] srd_fill(input int unsigned idx);
        return 8'(idx * 29 + 167);
    endfunction

endpackage

// File: rtl/srd_line_mon.sv
// Line monitor: synchronises the bus clock and data, then flags clock edges
// and start/stop conditions as single-cycle pulses.
// Assumes both lines are far slower than clk and are synchronised with the
// same latency, so their relative order is kept.
module srd_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronise both lines; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_STAGES-1];
            sda_d    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_p  = scl_s & scl_d & ~sda_s & sda_d;
        stop_p   = scl_s & scl_d & sda_s & ~sda_d;
    end
endmodule

// File: rtl/srd_mem.sv
// Read-only register array. Reset fills it with the package pattern, and
// the read port is combinational.
// Assumes 2**ADDR_W stays small (a few hundred entries at most).
module srd_mem
    import srd_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Load the fill pattern on reset; the cell holds otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) cell_q[g] <= DATA_W'(srd_fill(g));
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/srd_ctrl.sv
// Protocol controller: takes the header and the word address, keeps the
// shared address counter, and shifts data out while watching the master's
// ninth-clock acknowledge.
// Assumes single-cycle edge and condition pulses from the line monitor.
// Start and stop override every state.
module srd_ctrl
    import srd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe,
    output srd_state_e        state_o
);
    srd_state_e        state_q;
    srd_byte_e         byte_q;
    logic [2:0]        cnt_q;
    logic [7:0]        sh_q;
    logic [7:0]        hi_q;
    logic              rw_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              oe_q;

    // Main sequencer: bus conditions first, then per-state clock-edge work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= BY_DEV;
            cnt_q   <= '0;
            sh_q    <= '0;
            hi_q    <= '0;
            rw_q    <= 1'b0;
            ptr_q   <= '0;
            oe_q    <= 1'b0;
        end else if (start_p) begin
            state_q <= ST_RX;
            byte_q  <= BY_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (stop_p) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX: if (scl_rise) begin
                    sh_q  <= {sh_q[6:0], sda_s};
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'd7) begin
                        unique case (byte_q)
                            BY_DEV: begin
                                if (sh_q[6:0] == DEV_ADDR) begin
                                    rw_q    <= sda_s;
                                    state_q <= ST_ACKPEND;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            BY_AHI: begin
                                hi_q    <= {sh_q[6:0], sda_s};
                                state_q <= ST_ACKPEND;
                            end
                            default: begin
                                ptr_q   <= ADDR_W'({hi_q, sh_q[6:0], sda_s});
                                state_q <= ST_ACKPEND;
                            end
                        endcase
                    end
                end
                ST_ACKPEND: if (scl_fall) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    cnt_q <= '0;
                    if (byte_q == BY_DEV && rw_q) begin
                        sh_q    <= rd_data;
                        oe_q    <= ~rd_data[7];
                        state_q <= ST_TX;
                    end else begin
                        oe_q <= 1'b0;
                        unique case (byte_q)
                            BY_DEV:  begin byte_q <= BY_AHI; state_q <= ST_RX; end
                            BY_AHI:  begin byte_q <= BY_ALO; state_q <= ST_RX; end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_TX: if (scl_fall) begin
                    cnt_q <= cnt_q + 3'd1;
                    if (cnt_q == 3'd7) begin
                        oe_q    <= 1'b0;
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= ST_MACK;
                    end else begin
                        oe_q <= ~sh_q[6];
                        sh_q <= {sh_q[6:0], 1'b0};
                    end
                end
                ST_MACK: if (scl_rise) begin
                    state_q <= sda_s ? ST_IDLE : ST_NEXT;
                end
                ST_NEXT: if (scl_fall) begin
                    sh_q    <= rd_data;
                    oe_q    <= ~rd_data[7];
                    cnt_q   <= '0;
                    state_q <= ST_TX;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr = ptr_q;
    assign sda_oe  = oe_q;
    assign state_o = state_q;
endmodule

// File: rtl/i2c_mem_read_slave.sv
// Top of the serial memory read slave: line monitor, controller and array.
// Assumes an external open-drain pad where sda_oe_o pulls the line low.
module i2c_mem_read_slave
    import srd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_p;
    logic              stop_p;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data;
    srd_state_e        state;

    srd_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    srd_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .rd_data  (rd_data),
        .rd_addr  (ptr),
        .sda_oe   (sda_oe_o),
        .state_o  (state)
    );

    srd_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/srd_checker.sv
// Checker for the serial memory read slave, bound to the top.
// Relates the monitor's pulses, the controller state, the counter and the
// pull-low enable over time.
module srd_checker
    import srd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_p,
    input logic              stop_p,
    input logic              sda_oe,
    input logic [ADDR_W-1:0] ptr,
    input srd_state_e        state
);
    // R13: the enable only rises after the synchronised clock was low
    a_r13_oe_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R12: a stop always leaves the line released
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_p) |-> !sda_oe);

    // R2: a start always leaves the line released
    a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_p) |-> !sda_oe);

    // R9: the counter moves by one, or is loaded while a byte is received
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> (ptr == $past(ptr) + 1'b1) || ($past(state) == ST_RX));

    // R10: in standby the line is never pulled low
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_mem_read_slave srd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .sda_oe  (sda_oe_o),
    .ptr     (ptr),
    .state   (state)
);

// File: tb/i2c_mem_read_slave_tb.sv
// Bench: open-drain bus model with a bit-banged master, directed corner
// cases and a seeded random mix of reads and address loads.
module i2c_mem_read_slave_tb;
    localparam logic [6:0] DEV   = 7'h50;
    localparam int         AW    = 5;
    localparam int         DEPTH = 1 << AW;
    localparam int         Q     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  bus = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int stab_err = 0;
    int mptr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_mem_read_slave #(.DEV_ADDR(DEV), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus), .sda_oe_o(sda_oe)
    );

    function automatic logic [7:0] exp_mem(input int a);
        return 8'(((a % DEPTH) * 29) + 167);
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        logic a, z;
        tick(Q); m_sda = b;
        tick(Q); m_scl = 1'b1;
        tick(1); a = bus;
        tick(Q - 1); seen = bus;
        tick(Q - 1); z = bus;
        if (a != seen || seen != z) stab_err++;
        tick(1); m_scl = 1'b0;
    endtask

    task automatic do_start;
        tick(Q); m_sda = 1'b1;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_sda = 1'b0;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic do_stop;
        tick(Q); m_sda = 1'b0;
        tick(Q); m_scl = 1'b1;
        tick(Q); m_sda = 1'b1;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_bits(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic s;
        read_bits(d);
        bit_io(~mack, s);
    endtask

    // Sequential read of n bytes from the model counter, nack on the last.
    task automatic seq_read(input int n, input string req);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, d);
            chk(d, exp_mem(mptr), req);
            mptr = (mptr + 1) % DEPTH;
        end
    endtask

    task automatic load_addr(input logic [15:0] a, input string req);
        logic ack;
        send_byte({DEV, 1'b0}, ack); chk(ack, 1, {req, " header ack"});
        send_byte(a[15:8], ack);     chk(ack, 1, "R4 high byte ack");
        send_byte(a[7:0], ack);      chk(ack, 1, "R4 low byte ack");
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int unsigned r;
        r = $urandom(32'd20240607);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk(sda_oe, 0, "R1 reset release");

        // R7/R1/R8: current read from counter 0 right after reset
        do_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R3 read header ack");
        seq_read(1, "R7 current read at 0");
        do_stop();

        // R6/R4: random read with high bits beyond the array width
        do_start();
        load_addr(16'h1207, "R6");
        mptr = 16'h1207 % DEPTH;
        do_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R6 read header ack");
        seq_read(1, "R6 random read data");
        do_stop();

        // R5 then R9: set current address near the top, then wrap
        do_start();
        load_addr(16'h001E, "R5");
        do_stop();
        mptr = 30;
        do_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R5 read header ack");
        seq_read(5, "R9 sequential wrap");
        do_stop();

        // R3: mismatched address, no ack, later bytes ignored
        do_start();
        send_byte({7'h51, 1'b1}, ack); chk(ack, 0, "R3 mismatch no ack");
        read_bits(d); chk(d, 8'hFF, "R3 ignored after mismatch");
        send_byte(8'h00, ack); chk(ack, 0, "R3 no ack after mismatch");
        do_stop();

        // R10: nack, then further clocks leave the line released
        do_start();
        send_byte({DEV, 1'b1}, ack);
        seq_read(1, "R10 byte before nack");
        read_bits(d); chk(d, 8'hFF, "R10 quiet after nack");
        do_stop();

        // R11: stop in the ninth clock, counter already advanced
        do_start();
        send_byte({DEV, 1'b1}, ack);
        read_bits(d); chk(d, exp_mem(mptr), "R11 byte before stop");
        mptr = (mptr + 1) % DEPTH;
        do_stop();
        do_start();
        send_byte({DEV, 1'b1}, ack);
        seq_read(1, "R11 next address after stop");
        do_stop();

        // R12: bytes clocked after a stop without a start are ignored
        send_byte({DEV, 1'b1}, ack); chk(ack, 0, "R12 no ack without start");
        read_bits(d); chk(d, 8'hFF, "R12 line quiet");

        // R2: start in the middle of a word address byte restarts the header
        do_start();
        send_byte({DEV, 1'b0}, ack);
        for (int i = 0; i < 3; i++) bit_io(1'b0, ack);
        do_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R2 restart header ack");
        seq_read(2, "R2 read after mid-byte start");
        do_stop();

        // Random mix of random reads, address loads and current reads
        for (int it = 0; it < 24; it++) begin
            int op;
            int n;
            logic [15:0] a;
            op = int'($urandom_range(0, 2));
            n  = int'($urandom_range(1, 6));
            a  = 16'($urandom);
            do_start();
            if (op == 0) begin
                load_addr(a, "R6");
                mptr = a % DEPTH;
                do_start();
                send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R6 random header ack");
                seq_read(n, "R6 random sequence");
            end else if (op == 1) begin
                load_addr(a, "R5");
                mptr = a % DEPTH;
            end else begin
                send_byte({DEV, 1'b1}, ack); chk(ack, 1, "R7 current header ack");
                seq_read(n, "R7 current sequence");
            end
            do_stop();
        end

        chk(stab_err, 0, "R13 line stable while clock high");
        done = 1;
        report();
        $finish;
    end
endmodule